// File: doc/BRIEF.md
# Linear Flash Read Sequencer

This block answers 32-bit memory-mapped reads from a serial NOR flash. It keeps one line of 1024 bytes in local storage. A read whose word falls inside the stored line completes at once from that storage. Any other read starts a refill. The refill selects one of two flash chips and sends a read command header on a byte-stream interface toward an external serial shifter. The header holds the opcode, three address bytes, an optional mode byte and a programmable run of dummy bytes. The block throws away the bytes that come back during the header. It then clocks out 1024 zero bytes and packs the 1024 returned bytes into the line. Last, it releases the chip select and completes the waiting read from the line.

The requester uses a valid/ready handshake. It holds `req_valid` and its address until the cycle in which `req_ready` is high. In that cycle `rd_data` and `rd_err` are valid. The command header comes from a 32-bit configuration word, which the block samples when a refill starts. A typical value is 0x03A002EB: opcode 0xEB, mode byte 0xA0 enabled, two dummy bytes. A bus-count input halves the flash address when two flash buses are used side by side. The byte-stream side has one byte in flight at a time. Each byte that is offered and accepted is answered by exactly one returned byte.

Top module: `flash_line_reader`

## Requirements
- R1: After reset both chip selects are high, `tx_valid` is low, `req_ready` is low while no request is present, and the line is empty, so the first word read always refills.
- R2: A request with `req_size` other than 2 (0 = byte, 1 = halfword, 2 = word) or with `req_addr[1:0]` nonzero completes in the cycle it is presented, with `rd_err` = 1 and no flash traffic.
- R3: A word read at address A with base <= A <= base + 1020 (base is the line base) completes with no flash traffic. It returns the stored word at offset A - base.
- R4: A word read outside that window starts a refill. After the refill the line base equals A and the read completes from the new line.
- R5: The header starts with the opcode `cfg[7:0]`. Three flash-address bytes follow, most significant first, carrying flash address bits 23:0.
- R6: When `cfg[25]` is 1, the byte `cfg[23:16]` follows the address bytes. When `cfg[25]` is 0, no mode byte is sent.
- R7: After that, `cfg[10:8]` zero-valued dummy bytes are sent. Every byte sent during the data phase is zero.
- R8: The flash address is A shifted right by one when `dual_bus` is 1, and A itself otherwise. Its bit 24 picks the chip: `cs_n[0]` is driven low for 0 and `cs_n[1]` for 1. At most one chip select is low, only during a refill, and it does not change while low.
- R9: A refill takes exactly 1024 data bytes after the header. Data byte n is stored in byte lane n mod 4 (bits 8(n mod 4)+7 down to 8(n mod 4)) of line word n/4. The chip select then returns high.
- R10: `req_ready` stays low for the whole refill. `tx_valid` and `tx_byte` hold steady until `tx_ready` accepts the byte.
- R11: Bytes returned during the header never reach the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Read completes this cycle |
| req_addr | input | ADDR_W (26) | Byte address of the read |
| req_size | input | 2 | Access size code, only 2 (word) accepted |
| rd_data | output | 32 | Read word, valid with req_ready |
| rd_err | output | 1 | Rejected access, valid with req_ready |
| cfg | input | 32 | Linear read configuration word |
| dual_bus | input | 1 | Two effective flash buses |
| cs_n | output | 2 | Active-low chip selects |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_ready | input | 1 | Shifter accepts the byte |
| tx_byte | output | 8 | Byte to send |
| rx_valid | input | 1 | Returned byte present |
| rx_byte | input | 8 | Returned byte |

## Verification
The assertions check, on every cycle, the properties that hold at the byte interface regardless of scenario. These are that at most one chip select is low, that a select holds steady while low, that no byte is offered without a select, that an offered byte is held until it is taken, that no read completes during a refill, and that rejected accesses never coincide with flash activity. Only the bench scenarios can show the rest. These are the exact header contents for several configuration words, the chip choice and address halving with two buses, the hit window edges (last word in, one word past, one word below), the byte packing of the refilled line, and that header responses are discarded.

// File: rtl/flr_pkg.sv
package flr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_DONE
  } flr_state_e;

  // configuration word field positions
  localparam int OPC_LSB     = 0;
  localparam int DUMMY_LSB   = 8;
  localparam int DUMMY_W     = 3;
  localparam int MODE_LSB    = 16;
  localparam int MODE_EN_BIT = 25;

  localparam logic [1:0] SIZE_WORD = 2'd2;

endpackage

// File: rtl/flr_header.sv
module flr_header
  import flr_pkg::*;
#(
  parameter int FA_BYTES = 3,
  parameter int IDX_W    = 4
) (
  input  logic [31:0]           cfg_q,
  input  logic [8*FA_BYTES-1:0] faddr,
  input  logic [IDX_W-1:0]      idx,
  output logic [IDX_W-1:0]      hdr_len,
  output logic [7:0]            hdr_byte
);

  localparam int MODE_POS = 1 + FA_BYTES;

  logic               mode_en;
  logic [DUMMY_W-1:0] n_dummy;
  logic [7:0]         addr_bytes [FA_BYTES];
  logic               unused_cfg;

  // address bytes leave most significant first
  genvar g;
  generate
    for (g = 0; g < FA_BYTES; g++) begin : g_abyte
      assign addr_bytes[g] = faddr[8*(FA_BYTES-1-g) +: 8];
    end
  endgenerate

  assign mode_en    = cfg_q[MODE_EN_BIT];
  assign n_dummy    = cfg_q[DUMMY_LSB +: DUMMY_W];
  assign unused_cfg = ^{cfg_q[31:26], cfg_q[24], cfg_q[15:11]};

  always_comb begin
    hdr_len  = IDX_W'(1 + FA_BYTES) + IDX_W'(mode_en) + IDX_W'(n_dummy);
    hdr_byte = 8'h00;
    if (idx == '0) begin
      hdr_byte = cfg_q[OPC_LSB +: 8];
    end
    for (int i = 0; i < FA_BYTES; i++) begin
      if (idx == IDX_W'(i + 1)) begin
        hdr_byte = addr_bytes[i];
      end
    end
    if (mode_en && (idx == IDX_W'(MODE_POS))) begin
      hdr_byte = cfg_q[MODE_LSB +: 8];
    end
  end

endmodule

// File: rtl/flr_line_buf.sv
module flr_line_buf #(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 1024,
  localparam int BCNT_W    = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [BCNT_W-1:0] byte_idx,
  input  logic [7:0]        byte_in,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_base,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit,
  output logic [31:0]       rd_word
);

  localparam int WORDS    = LINE_BYTES / 4;
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int LAST_OFF = LINE_BYTES - 4;

  logic [31:0]       mem [WORDS];
  logic [23:0]       acc_q, acc_d;
  logic              acc_en;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              word_we;
  logic [WIDX_W-1:0] wr_idx;
  logic [31:0]       wr_word;
  logic [ADDR_W-1:0] off;
  logic [1:0]        lane;

  assign lane    = byte_idx[1:0];
  assign wr_idx  = byte_idx[BCNT_W-1:2];
  assign word_we = byte_we && (lane == 2'd3);
  assign wr_word = {byte_in, acc_q};
  assign acc_en  = byte_we && (lane != 2'd3);

  // byte assembly: lanes 0..2 collect, lane 3 completes the word
  always_comb begin
    acc_d = acc_q;
    case (lane)
      2'd0:    acc_d[7:0]   = byte_in;
      2'd1:    acc_d[15:8]  = byte_in;
      2'd2:    acc_d[23:16] = byte_in;
      default: acc_d        = acc_q;
    endcase
  end

  always_comb begin
    valid_d = valid_q | commit;
    base_d  = commit ? commit_base : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      valid_q <= 1'b0;
      base_q  <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (commit) begin
        valid_q <= valid_d;
        base_q  <= base_d;
      end
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (word_we) mem[wr_idx] <= wr_word;
  end

  assign off     = rd_addr - base_q;
  assign hit     = valid_q && (rd_addr >= base_q) && (off <= ADDR_W'(LAST_OFF));
  assign rd_word = mem[off[BCNT_W-1:2]];

endmodule

// File: rtl/flr_ctrl.sv
module flr_ctrl
  import flr_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 1024,
  parameter int CHIP_BIT   = 24,
  parameter int FA_BYTES   = 3,
  parameter int IDX_W      = 4,
  localparam int BCNT_W    = $clog2(LINE_BYTES),
  localparam int FA_W      = 8 * FA_BYTES,
  localparam int CS_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              dual_bus,
  input  logic [31:0]       cfg,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hdr_len,
  input  logic              tx_ready,
  input  logic              rx_valid,
  output logic              req_ready,
  output logic              rd_err,
  output logic              tx_valid,
  output logic              in_data,
  output logic [IDX_W-1:0]  hdr_idx,
  output logic              byte_we,
  output logic [BCNT_W-1:0] byte_idx,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_base,
  output logic [31:0]       cfg_q,
  output logic [FA_W-1:0]   faddr_q,
  output logic [CS_W-1:0]   cs_n
);

  flr_state_e        state_q, state_d;
  logic [BCNT_W-1:0] cnt_q, cnt_d;
  logic              data_q, data_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] fa_q, fa_next;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic              bad;
  logic              start;
  logic              unused_fa;

  assign bad     = (req_size != SIZE_WORD) || (req_addr[1:0] != 2'b00);
  assign fa_next = dual_bus ? (req_addr >> 1) : req_addr;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    data_d    = data_q;
    cs_d      = cs_q;
    start     = 1'b0;
    req_ready = 1'b0;
    rd_err    = 1'b0;
    tx_valid  = 1'b0;
    byte_we   = 1'b0;
    commit    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (bad) begin
            req_ready = 1'b1;
            rd_err    = 1'b1;
          end else if (hit) begin
            req_ready = 1'b1;
          end else begin
            start   = 1'b1;
            cnt_d   = '0;
            data_d  = 1'b0;
            cs_d    = ~(CS_W'(1) << fa_next[CHIP_BIT]);
            state_d = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        tx_valid = 1'b1;
        if (tx_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rx_valid) begin
          if (data_q) begin
            byte_we = 1'b1;
            if (cnt_q == BCNT_W'(LINE_BYTES - 1)) begin
              cs_d    = '1;
              state_d = ST_DONE;
            end else begin
              cnt_d   = cnt_q + 1'b1;
              state_d = ST_SEND;
            end
          end else begin
            if (cnt_q + 1'b1 == BCNT_W'(hdr_len)) begin
              cnt_d  = '0;
              data_d = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
            state_d = ST_SEND;
          end
        end
      end
      default: begin
        commit  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      data_q  <= 1'b0;
      cs_q    <= '1;
      addr_q  <= '0;
      fa_q    <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      cs_q    <= cs_d;
      if (start) begin
        addr_q <= req_addr;
        fa_q   <= fa_next;
        cfg_q  <= cfg;
      end
    end
  end

  assign in_data     = data_q;
  assign hdr_idx     = cnt_q[IDX_W-1:0];
  assign byte_idx    = cnt_q;
  assign commit_base = addr_q;
  assign faddr_q     = fa_q[FA_W-1:0];
  assign cs_n        = cs_q;
  assign unused_fa   = ^fa_q[ADDR_W-1:FA_W];

  AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && ($past(cs_n) != '1)) |-> $stable(cs_n)) else $error("cs changed while low"); // R8
  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (cs_n == '1)) else $error("error response during refill"); // R2

endmodule

// File: rtl/flash_line_reader.sv
module flash_line_reader #(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 1024,
  parameter int CHIP_BIT   = 24,
  parameter int FA_BYTES   = 3,
  localparam int IDX_W     = 4,
  localparam int BCNT_W    = $clog2(LINE_BYTES),
  localparam int FA_W      = 8 * FA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic [31:0]       rd_data,
  output logic              rd_err,
  input  logic [31:0]       cfg,
  input  logic              dual_bus,
  output logic [1:0]        cs_n,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte
);

  logic              hit;
  logic [IDX_W-1:0]  hdr_len;
  logic [IDX_W-1:0]  hdr_idx;
  logic [7:0]        hdr_byte;
  logic              in_data;
  logic              byte_we;
  logic [BCNT_W-1:0] byte_idx;
  logic              commit;
  logic [ADDR_W-1:0] commit_base;
  logic [31:0]       cfg_q;
  logic [FA_W-1:0]   faddr_q;

  flr_ctrl #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .CHIP_BIT   (CHIP_BIT),
    .FA_BYTES   (FA_BYTES),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .dual_bus    (dual_bus),
    .cfg         (cfg),
    .hit         (hit),
    .hdr_len     (hdr_len),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .req_ready   (req_ready),
    .rd_err      (rd_err),
    .tx_valid    (tx_valid),
    .in_data     (in_data),
    .hdr_idx     (hdr_idx),
    .byte_we     (byte_we),
    .byte_idx    (byte_idx),
    .commit      (commit),
    .commit_base (commit_base),
    .cfg_q       (cfg_q),
    .faddr_q     (faddr_q),
    .cs_n        (cs_n)
  );

  flr_header #(
    .FA_BYTES (FA_BYTES),
    .IDX_W    (IDX_W)
  ) u_header (
    .cfg_q    (cfg_q),
    .faddr    (faddr_q),
    .idx      (hdr_idx),
    .hdr_len  (hdr_len),
    .hdr_byte (hdr_byte)
  );

  flr_line_buf #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_line (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_we     (byte_we),
    .byte_idx    (byte_idx),
    .byte_in     (rx_byte),
    .commit      (commit),
    .commit_base (commit_base),
    .rd_addr     (req_addr),
    .hit         (hit),
    .rd_word     (rd_data)
  );

  // data phase clocks out zeros, header phase sends the built header
  assign tx_byte = in_data ? 8'h00 : hdr_byte;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)) else $error("two chip selects low"); // R8
  AST_TX_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (cs_n != 2'b11)) else $error("byte offered without select"); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))) else $error("byte dropped"); // R10
  AST_NO_READY_IN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 2'b11) |-> !req_ready) else $error("read completed during refill"); // R10

endmodule

// File: tb/flash_line_reader_bench.sv
module flash_line_reader_bench;

  localparam int AW = 26;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd2;
  logic [31:0]   rd_data;
  logic          rd_err;
  logic [31:0]   cfg = 32'h03A002EB;
  logic          dual_bus = 1'b0;
  logic [1:0]    cs_n;
  logic          tx_valid;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_byte;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = 8'h00;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_line_reader u_flash_line_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .rd_data(rd_data), .rd_err(rd_err),
    .cfg(cfg), .dual_bus(dual_bus), .cs_n(cs_n), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  function automatic logic [7:0] pat(input logic chip, input logic [23:0] fa);
    return 8'(fa[7:0] + 8'(fa[15:8] * 3) + 8'(fa[23:16] * 5) + (chip ? 8'h5A : 8'h00));
  endfunction

  // flash model: one reply per accepted byte, garbage during the header
  int         cyc = 0;
  int         n_byte = 0;
  int         refills = 0;
  int         nz_data = 0;
  int         chip_seen = 0;
  logic [1:0] cs_prev = 2'b11;
  logic [7:0] hdr_log [16];
  logic [4:0] hlen_m;

  assign hlen_m = 5'd4 + 5'(cfg[25]) + 5'(cfg[10:8]);

  always @(posedge clk) begin
    int n;
    cyc      <= cyc + 1;
    tx_ready <= (cyc % 3) != 2;
    rx_valid <= 1'b0;
    cs_prev  <= cs_n;
    n = n_byte;
    if (rst_n) begin
      if (cs_n != 2'b11 && cs_prev == 2'b11) begin
        refills   <= refills + 1;
        n         = 0;
        chip_seen <= (cs_n == 2'b10) ? 0 : ((cs_n == 2'b01) ? 1 : 9);
      end
      if (tx_valid && tx_ready) begin
        if (n < 16) hdr_log[n] <= tx_byte;
        if (n < int'(hlen_m)) begin
          rx_byte <= 8'hA5;
        end else begin
          rx_byte <= pat(cs_n == 2'b01, {hdr_log[1], hdr_log[2], hdr_log[3]} + 24'(n - int'(hlen_m)));
          if (tx_byte != 8'h00) nz_data <= nz_data + 1;
        end
        rx_valid <= 1'b1;
        n = n + 1;
      end
      n_byte <= n;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [AW-1:0] base, input logic [AW-1:0] a, input logic dual);
    logic [AW-1:0] fb;
    logic [31:0]   w;
    fb = dual ? (base >> 1) : base;
    for (int k = 0; k < 4; k++)
      w[8*k +: 8] = pat(fb[24], fb[23:0] + 24'(a - base) + 24'(k));
    return w;
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz,
                         output logic [31:0] d, output logic e, output int lat, output int nref);
    int r0;
    r0  = refills;
    lat = 0;
    @(negedge clk);
    req_addr  = a;
    req_size  = sz;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
      lat++;
    end
    d = rd_data;
    e = rd_err;
    @(negedge clk);
    req_valid = 1'b0;
    nref = refills - r0;
  endtask

  task automatic check_hdr(input logic [23:0] fa, input logic [31:0] c);
    int idx;
    idx = 4;
    check(hdr_log[0] == c[7:0], "R5 opcode", 32'(hdr_log[0]), 32'(c[7:0]));
    for (int k = 0; k < 3; k++)
      check(hdr_log[1+k] == fa[23-8*k -: 8], "R5 address byte", 32'(hdr_log[1+k]), 32'(fa[23-8*k -: 8]));
    if (c[25]) begin
      check(hdr_log[4] == c[23:16], "R6 mode byte", 32'(hdr_log[4]), 32'(c[23:16]));
      idx = 5;
    end
    for (int j = 0; j < int'(c[10:8]); j++)
      check(hdr_log[idx+j] == 8'h00, "R7 dummy byte", 32'(hdr_log[idx+j]), 32'h0);
    check(n_byte == idx + int'(c[10:8]) + 1024, "R6 R7 R9 byte count", 32'(n_byte),
          32'(idx + int'(c[10:8]) + 1024));
  endtask

  // {address, size, expect refill, expect error}
  localparam logic [29:0] VEC [NV] = '{
    {26'h0000100, 2'd2, 1'b1, 1'b0},
    {26'h0000104, 2'd2, 1'b0, 1'b0},
    {26'h00004FC, 2'd2, 1'b0, 1'b0},
    {26'h0000500, 2'd2, 1'b1, 1'b0},
    {26'h00004FC, 2'd2, 1'b1, 1'b0},
    {26'h0000102, 2'd2, 1'b0, 1'b1},
    {26'h0000500, 2'd1, 1'b0, 1'b1},
    {26'h1000020, 2'd2, 1'b1, 1'b0},
    {26'h1000024, 2'd2, 1'b0, 1'b0}
  };

  logic [AW-1:0] base_m = '0;

  task automatic run_read(input logic [AW-1:0] a, input logic [1:0] sz, input bit m, input bit e);
    logic [31:0]   d;
    logic          er;
    int            lat, nref;
    logic [AW-1:0] fb;
    do_read(a, sz, d, er, lat, nref);
    check(er == e, "R2 error flag", 32'(er), 32'(e));
    if (e) begin
      check(nref == 0 && lat == 0, "R2 no traffic", 32'(nref), 32'h0);
    end else begin
      check(nref == int'(m), m ? "R4 refill" : "R3 hit", 32'(nref), 32'(m));
      if (m) begin
        base_m = a;
        fb = dual_bus ? (a >> 1) : a;
        check(chip_seen == int'(fb[24]), "R8 chip", 32'(chip_seen), 32'(fb[24]));
        check_hdr(fb[23:0], cfg);
        check(lat >= 2048, "R10 stall", 32'(lat), 32'd2048);
        check(cs_n == 2'b11, "R9 release", 32'(cs_n), 32'h3);
      end
      check(d == exp_word(base_m, a, dual_bus), "R9 R11 data", d, exp_word(base_m, a, dual_bus));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(cs_n == 2'b11, "R1 cs after reset", 32'(cs_n), 32'h3);
    check(tx_valid == 1'b0, "R1 tx idle", 32'(tx_valid), 32'h0);
    check(req_ready == 1'b0, "R1 ready idle", 32'(req_ready), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (i == 0) begin
        int r0;
        r0 = refills;
        run_read(VEC[i][29:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
        check(refills - r0 == 1, "R1 first read refills", 32'(refills - r0), 32'h1);
      end else begin
        run_read(VEC[i][29:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
      end
    end

    // two buses, no mode byte, no dummies
    cfg      = 32'h00000003;
    dual_bus = 1'b1;
    run_read(26'h2000040, 2'd2, 1'b1, 1'b0);
    run_read(26'h2000044, 2'd2, 1'b0, 1'b0);

    // one bus, mode byte and three dummies
    cfg      = 32'h0255036B;
    dual_bus = 1'b0;
    run_read(26'h0800000, 2'd2, 1'b1, 1'b0);
    run_read(26'h08003FC, 2'd2, 1'b0, 1'b0);
    run_read(26'h0800400, 2'd2, 1'b1, 1'b0);

    check(nz_data == 0, "R7 data phase zeros", 32'(nz_data), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule